// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a core's load/store unit and a data memory that is one 32-bit word wide and addressed in bytes. On the store side it turns a byte address, an access size and the register value into a word address, per-lane byte enables and write data already placed in the right lanes. On the load side it accepts the word returned by memory and picks out the byte, halfword or word the request named. Sub-word results are sign-extended or zero-extended to 32 bits as the request asks. The result comes out one cycle later on a valid/ready response port.

A single mode pin picks the lane order. Low (the default) is big-endian: the lowest byte address in a word is the most significant byte, so offset 0 is lane 3 (bits 31:24). High is little-endian: offset 0 is lane 0 (bits 7:0). An access that is not aligned to its own size raises a flag. A misaligned store writes nothing. A misaligned load returns zero with the flag set.

Back-pressure on the load path: a returned word is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the one-entry response slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds its data and flag, and no new word is accepted. The store path is combinational and has no handshake.

Top module: `lsu_lane_aligner`

## Requirements
- R1: After reset, `rsp_valid` is low and no byte enable is asserted while `st_valid` is low.
- R2: A byte store (size code 00) at byte offset o asserts exactly one enable. In big-endian mode it is lane 3-o; in little-endian mode it is lane o. The data byte is copied into all four lanes of `mem_wr_data`.
- R3: A halfword store (size code 01) at offset 0 or 2 enables the two lanes that hold offsets o and o+1 in the current lane order. `mem_wr_data` carries the low 16 bits of `st_data` twice, as {h,h}.
- R4: A word store (size code 10) at offset 0 enables all four lanes and passes `st_data` unchanged in either mode.
- R5: A store is misaligned if it is a halfword with address bit 0 set, a word with either low address bit set, or uses size code 11. A misaligned valid store raises `st_misalign` and asserts no byte enable.
- R6: `mem_wr_addr` equals `st_addr` with its two low bits dropped.
- R7: A byte load returns the byte at offset o under the current lane order. It is zero-extended when `ld_unsigned` is 1 and sign-extended from bit 7 when it is 0.
- R8: A halfword load at offset 0 or 2 returns a 16-bit value. In big-endian mode offset o is the high byte; in little-endian mode offset o+1 is the high byte. It is extended to 32 bits as selected by `ld_unsigned`.
- R9: A word load at offset 0 returns the memory word unchanged in either mode.
- R10: An accepted read beat produces `rsp_valid` high at the next clock edge, carrying that beat's result.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rd_ready` is low and `rsp_data` and `rsp_misalign` stay stable.
- R12: A misaligned load, by the R5 rule, returns `rsp_data` of zero with `rsp_misalign` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| le_mode | input | 1 | 0 = big-endian lane order, 1 = little-endian |
| st_valid | input | 1 | Store request present |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size: 00 byte, 01 half, 10 word, 11 reserved |
| st_data | input | 32 | Store value, right-aligned |
| mem_wr_addr | output | 30 | Word address for memory |
| mem_byte_en | output | 4 | Per-lane write enables, bit k = bits 8k+7:8k |
| mem_wr_data | output | 32 | Lane-placed write data |
| st_misalign | output | 1 | Valid store is misaligned |
| rd_valid | input | 1 | Read word and its request fields present |
| rd_ready | output | 1 | Read beat can be accepted |
| rd_data | input | 32 | Word returned from memory |
| ld_addr | input | 32 | Load byte address for this beat |
| ld_size | input | 2 | Load size, same coding as the store size |
| ld_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| rsp_valid | output | 1 | Load result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 32 | Extended load result |
| rsp_misalign | output | 1 | Load was misaligned |

## Verification
The store packer and the load response path run side by side. A store request and an accepted read beat can therefore land on the same clock edge, with the lane order shared between them. The bench drives a halfword store and a signed byte load in the same cycle. It checks the enables and write data at once, and the response one edge later, each against its own reference. The response hold under back-pressure can also coincide with a new read beat waiting at the input. The bench holds `rsp_ready` low while a second beat is offered and checks that the first result stays put. When `rsp_ready` rises, it checks that the second beat is the one that arrives.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // True when an access of the given size at the given in-word offset
  // cannot be served as one aligned memory word access.
  function automatic logic is_misaligned(input acc_size_e sz, input logic [1:0] off);
    logic bad;
    unique case (sz)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = |off;
      default: bad = 1'b1;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/lsu_lane_map.sv
// Maps an in-word byte offset onto a physical lane for the chosen order.
module lsu_lane_map #(
  parameter int NUM_LANES = 4,
  localparam int OFF_W = $clog2(NUM_LANES)
) (
  input  logic             le_mode,
  input  logic [OFF_W-1:0] offset,
  output logic [OFF_W-1:0] byte_lane,
  output logic [OFF_W-1:0] pair_lane
);
  logic [OFF_W-1:0] off_even;

  always_comb begin
    off_even = {offset[OFF_W-1:1], 1'b0};
    if (le_mode) begin
      byte_lane = offset;
      pair_lane = off_even;
    end else begin
      byte_lane = OFF_W'(NUM_LANES - 1) - offset;
      pair_lane = OFF_W'(NUM_LANES - 2) - off_even;
    end
  end
endmodule

// File: rtl/lsu_store_pack.sv
// Builds per-lane enables and lane-placed data for a store.
module lsu_store_pack
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              enable,
  input  acc_size_e         size,
  input  logic              le_mode,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] data,
  output logic [NB-1:0]     byte_en,
  output logic [DATA_W-1:0] wdata
);
  logic [OFF_W-1:0] byte_lane;
  logic [OFF_W-1:0] pair_lane;
  logic [OFF_W-1:0] pair_hi;

  lsu_lane_map #(.NUM_LANES(NB)) i_map (
    .le_mode  (le_mode),
    .offset   (offset),
    .byte_lane(byte_lane),
    .pair_lane(pair_lane)
  );

  assign pair_hi = {pair_lane[OFF_W-1:1], 1'b1};

  for (genvar k = 0; k < NB; k++) begin : g_lane
    logic hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (byte_lane == OFF_W'(k));
        SZ_HALF: hit = (pair_lane == OFF_W'(k)) || (pair_hi == OFF_W'(k));
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
      byte_en[k] = enable & hit;
    end

    always_comb begin
      unique case (size)
        SZ_BYTE: wdata[8*k +: 8] = data[7:0];
        SZ_HALF: wdata[8*k +: 8] = (k % 2 == 1) ? data[15:8] : data[7:0];
        default: wdata[8*k +: 8] = data[8*k +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
// Selects and extends the addressed part of a returned memory word.
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  acc_size_e         size,
  input  logic              zero_ext,
  input  logic              le_mode,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [OFF_W-1:0] byte_lane;
  logic [OFF_W-1:0] pair_lane;
  logic [OFF_W+2:0] byte_shift;
  logic [OFF_W+2:0] pair_shift;
  logic [7:0]       byte_val;
  logic [15:0]      half_val;

  lsu_lane_map #(.NUM_LANES(NB)) i_map (
    .le_mode  (le_mode),
    .offset   (offset),
    .byte_lane(byte_lane),
    .pair_lane(pair_lane)
  );

  always_comb begin
    byte_shift = {byte_lane, 3'b000};
    pair_shift = {pair_lane, 3'b000};
    byte_val   = 8'(rdata >> byte_shift);
    half_val   = 16'(rdata >> pair_shift);
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){~zero_ext & byte_val[7]}}, byte_val};
      SZ_HALF: result = {{(DATA_W-16){~zero_ext & half_val[15]}}, half_val};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_rsp_slot.sv
// One-entry valid/ready output register for load results.
module lsu_rsp_slot #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int NB = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    le_mode,
  input  logic                    st_valid,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [1:0]              st_size,
  input  logic [DATA_W-1:0]       st_data,
  output logic [ADDR_W-OFF_W-1:0] mem_wr_addr,
  output logic [NB-1:0]           mem_byte_en,
  output logic [DATA_W-1:0]       mem_wr_data,
  output logic                    st_misalign,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [DATA_W-1:0]       rd_data,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [1:0]              ld_size,
  input  logic                    ld_unsigned,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_misalign
);
  acc_size_e         st_sz;
  acc_size_e         ld_sz;
  logic              st_bad;
  logic              ld_bad;
  logic [DATA_W-1:0] ld_result;
  logic [DATA_W:0]   slot_in;
  logic [DATA_W:0]   slot_out;

  assign st_sz  = acc_size_e'(st_size);
  assign ld_sz  = acc_size_e'(ld_size);
  assign st_bad = is_misaligned(st_sz, st_addr[1:0]);
  assign ld_bad = is_misaligned(ld_sz, ld_addr[1:0]);

  assign mem_wr_addr = st_addr[ADDR_W-1:OFF_W];
  assign st_misalign = st_valid & st_bad;

  lsu_store_pack #(.DATA_W(DATA_W)) i_pack (
    .enable (st_valid & ~st_bad),
    .size   (st_sz),
    .le_mode(le_mode),
    .offset (st_addr[OFF_W-1:0]),
    .data   (st_data),
    .byte_en(mem_byte_en),
    .wdata  (mem_wr_data)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) i_extract (
    .size    (ld_sz),
    .zero_ext(ld_unsigned),
    .le_mode (le_mode),
    .offset  (ld_addr[OFF_W-1:0]),
    .rdata   (rd_data),
    .result  (ld_result)
  );

  assign slot_in = {ld_bad, ld_bad ? '0 : ld_result};

  lsu_rsp_slot #(.W(DATA_W + 1)) i_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rd_valid),
    .in_ready (rd_ready),
    .in_data  (slot_in),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (slot_out)
  );

  assign rsp_misalign = slot_out[DATA_W];
  assign rsp_data     = slot_out[DATA_W-1:0];
endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic [1:0]        st_size,
  input logic [NB-1:0]     mem_byte_en,
  input logic              st_misalign,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_misalign
);
  a_r1_no_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> mem_byte_en == '0);

  a_r2_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_size == 2'b00) |-> $onehot(mem_byte_en));

  a_r5_misalign_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    st_misalign |-> mem_byte_en == '0);

  a_r10_rsp_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_misalign)));

  a_r11_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);

  a_r12_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_misalign) |-> rsp_data == '0);
endmodule

bind lsu_lane_aligner lsu_align_checker #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_valid    (st_valid),
  .st_size     (st_size),
  .mem_byte_en (mem_byte_en),
  .st_misalign (st_misalign),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .rsp_misalign(rsp_misalign)
);

// File: tb/test_lsu_lane_aligner.sv
module test_lsu_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        le_mode = 1'b0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic [31:0] st_data = '0;
  logic [29:0] mem_wr_addr;
  logic [3:0]  mem_byte_en;
  logic [31:0] mem_wr_data;
  logic        st_misalign;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_data = '0;
  logic [31:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic        ld_unsigned = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_misalign;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lsu_lane_aligner i_lsu_lane_aligner (.*);

  localparam logic [31:0] MEMW = 32'h81_22_F3_44;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] w, input int o, input logic le);
    int lane = le ? o : 3 - o;
    return 8'(w >> (8 * lane));
  endfunction

  function automatic logic [15:0] mem_half(input logic [31:0] w, input int o, input logic le);
    if (le) return {mem_byte(w, o + 1, le), mem_byte(w, o, le)};
    return {mem_byte(w, o, le), mem_byte(w, o + 1, le)};
  endfunction

  task automatic drive_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d;
    #1;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input logic uns,
                         output logic [31:0] d, output logic m, output logic v);
    @(negedge clk);
    ld_addr = a; ld_size = sz; ld_unsigned = uns; rd_data = MEMW; rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    v = rsp_valid; d = rsp_data; m = rsp_misalign;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R1 no enables idle", 32'(mem_byte_en), 0);
  endtask

  task automatic t_store_byte();
    for (int m = 0; m < 2; m++) begin
      le_mode = m[0];
      for (int o = 0; o < 4; o++) begin
        drive_store(32'h100 + 32'(o), 2'b00, 32'hDEAD_BE5A);
        chk($sformatf("R2 byte be le=%0d o=%0d", m, o), 32'(mem_byte_en),
            32'(1) << (m == 1 ? o : 3 - o));
        chk("R2 byte data", mem_wr_data, 32'h5A5A_5A5A);
      end
    end
  endtask

  task automatic t_store_half();
    for (int m = 0; m < 2; m++) begin
      le_mode = m[0];
      for (int o = 0; o < 4; o += 2) begin
        logic [3:0] exp_be;
        exp_be = (m == 1) ? (4'b0011 << o) : (4'b1100 >> o);
        drive_store(32'h200 + 32'(o), 2'b01, 32'h1234_C3A5);
        chk($sformatf("R3 half be le=%0d o=%0d", m, o), 32'(mem_byte_en), 32'(exp_be));
        chk("R3 half data", mem_wr_data, 32'hC3A5_C3A5);
      end
    end
  endtask

  task automatic t_store_word();
    for (int m = 0; m < 2; m++) begin
      le_mode = m[0];
      drive_store(32'h0000_1230, 2'b10, 32'hCAFE_F00D);
      chk("R4 word be", 32'(mem_byte_en), 32'hF);
      chk("R4 word data", mem_wr_data, 32'hCAFE_F00D);
      chk("R6 word address", 32'(mem_wr_addr), 32'h48C);
    end
    drive_store(32'h0000_1237, 2'b00, 32'h0);
    chk("R6 byte word address", 32'(mem_wr_addr), 32'h48D);
  endtask

  task automatic t_store_misalign();
    le_mode = 1'b0;
    drive_store(32'h301, 2'b01, 32'hFFFF);
    chk("R5 half odd flag", 32'(st_misalign), 1);
    chk("R5 half odd be", 32'(mem_byte_en), 0);
    drive_store(32'h302, 2'b10, 32'hFFFF_FFFF);
    chk("R5 word off2 flag", 32'(st_misalign), 1);
    chk("R5 word off2 be", 32'(mem_byte_en), 0);
    drive_store(32'h300, 2'b11, 32'hFFFF_FFFF);
    chk("R5 reserved size flag", 32'(st_misalign), 1);
    chk("R5 reserved size be", 32'(mem_byte_en), 0);
    drive_store(32'h303, 2'b00, 32'h1);
    chk("R5 byte never misaligned", 32'(st_misalign), 0);
    @(negedge clk);
    st_valid = 1'b0;
    #1;
    chk("R1 enables drop with st_valid", 32'(mem_byte_en), 0);
  endtask

  task automatic t_load_byte();
    logic [31:0] d; logic mis, v;
    for (int m = 0; m < 2; m++) begin
      le_mode = m[0];
      for (int o = 0; o < 4; o++) begin
        logic [7:0] b;
        b = mem_byte(MEMW, o, m[0]);
        do_load(32'h40 + 32'(o), 2'b00, 1'b1, d, mis, v);
        chk("R10 byte valid", 32'(v), 1);
        chk($sformatf("R7 ubyte le=%0d o=%0d", m, o), d, {24'h0, b});
        do_load(32'h40 + 32'(o), 2'b00, 1'b0, d, mis, v);
        chk($sformatf("R7 sbyte le=%0d o=%0d", m, o), d, {{24{b[7]}}, b});
      end
    end
  endtask

  task automatic t_load_half();
    logic [31:0] d; logic mis, v;
    for (int m = 0; m < 2; m++) begin
      le_mode = m[0];
      for (int o = 0; o < 4; o += 2) begin
        logic [15:0] h;
        h = mem_half(MEMW, o, m[0]);
        do_load(32'h80 + 32'(o), 2'b01, 1'b1, d, mis, v);
        chk($sformatf("R8 uhalf le=%0d o=%0d", m, o), d, {16'h0, h});
        do_load(32'h80 + 32'(o), 2'b01, 1'b0, d, mis, v);
        chk($sformatf("R8 shalf le=%0d o=%0d", m, o), d, {{16{h[15]}}, h});
        chk("R8 no flag", 32'(mis), 0);
      end
    end
  endtask

  task automatic t_load_word();
    logic [31:0] d; logic mis, v;
    for (int m = 0; m < 2; m++) begin
      le_mode = m[0];
      do_load(32'hC0, 2'b10, 1'b0, d, mis, v);
      chk("R9 word load", d, MEMW);
    end
  endtask

  task automatic t_load_misalign();
    logic [31:0] d; logic mis, v;
    le_mode = 1'b0;
    do_load(32'h83, 2'b01, 1'b1, d, mis, v);
    chk("R12 half odd flag", 32'(mis), 1);
    chk("R12 half odd data", d, 0);
    do_load(32'h81, 2'b10, 1'b0, d, mis, v);
    chk("R12 word off1 flag", 32'(mis), 1);
    chk("R12 word off1 data", d, 0);
  endtask

  task automatic t_backpressure();
    le_mode = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b0;
    ld_addr = 32'h0; ld_size = 2'b10; ld_unsigned = 1'b0; rd_data = 32'h1111_2222; rd_valid = 1'b1;
    @(negedge clk);
    chk("R10 first result", rsp_data, 32'h1111_2222);
    rd_data = 32'h3333_4444;
    chk("R11 rd_ready low when full", 32'(rd_ready), 0);
    repeat (2) @(negedge clk);
    chk("R11 held valid", 32'(rsp_valid), 1);
    chk("R11 held data", rsp_data, 32'h1111_2222);
    rsp_ready = 1'b1;
    #1;
    chk("R11 rd_ready while draining", 32'(rd_ready), 1);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R10 second result", rsp_data, 32'h3333_4444);
    @(negedge clk);
    chk("R10 drained", 32'(rsp_valid), 0);
  endtask

  task automatic t_concurrent();
    logic [7:0] b;
    le_mode = 1'b1;
    b = mem_byte(MEMW, 1, 1'b1);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h502; st_size = 2'b01; st_data = 32'h0000_9ABC;
    ld_addr = 32'h501; ld_size = 2'b00; ld_unsigned = 1'b0; rd_data = MEMW; rd_valid = 1'b1;
    #1;
    chk("R3 concurrent store be", 32'(mem_byte_en), 32'hC);
    chk("R3 concurrent store data", mem_wr_data, 32'h9ABC_9ABC);
    @(negedge clk);
    st_valid = 1'b0; rd_valid = 1'b0;
    chk("R10 concurrent valid", 32'(rsp_valid), 1);
    chk("R7 concurrent load", rsp_data, {{24{b[7]}}, b});
    le_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_store_byte();
    t_store_half();
    t_store_word();
    t_store_misalign();
    t_load_byte();
    t_load_half();
    t_load_word();
    t_load_misalign();
    t_backpressure();
    t_concurrent();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule